// File: doc/BRIEF.md
# Ethernet receive frame error checker

This block sits behind a receive deserializer and watches a serial bit stream, one bit per cycle when `rx_valid` is high. A frame opens with `rx_sof` on its first bit and closes with an `rx_eof` pulse that carries no bit. Between frames the checker waits in a hunt state and ignores everything except a new frame start.

Every bit is folded into a CRC-32. The value used for the verdict is the one captured at the last whole-octet boundary, so a trailing fragment of one to seven dribbling bits never affects the CRC verdict. When a frame closes, the block emits a one-cycle event strobe together with a status word and the count of whole octets. The status word says whether the CRC failed on an octet-aligned frame, whether a CRC failure came with dribbling bits (alignment error), and whether the frame was short and whether it is passed up. Two saturating counters tally CRC errors and alignment errors. CRC checking is always on, and software may only choose to disregard the result.

Top module: `eth_rx_frame_checker`

## Requirements
- R1: The CRC runs over frame bits in arrival order, each octet least significant bit first, with polynomial x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1 and a preset of all ones. A frame whose whole octets (data followed by the complemented CRC, sent low byte first) leave the residue 0xC704DD7B is CRC-good.
- R2: Between one and seven bits after the last whole octet are ignored by the CRC check. A CRC-good frame with such bits reports no error.
- R3: A frame that ends off an octet boundary and fails the CRC sets frm_status[1] (alignment error), leaves frm_status[0] clear, and adds one to align_err_count only.
- R4: An octet-aligned frame that fails the CRC sets frm_status[0] (CRC error), leaves frm_status[1] clear, and adds one to crc_err_count only.
- R5: In the cycle after rx_eof is sampled inside a frame, frm_evt is high for exactly one cycle, frm_status holds the verdict and frm_octets holds the number of whole octets received.
- R6: frm_status[2] (short) is set when the whole-octet count is below cfg_min_len. frm_status[3] (passed) is set when the frame is not short or cfg_accept_short is 1. The CRC and alignment verdicts apply to short frames as well.
- R7: Each error counter saturates at all ones and never wraps.
- R8: cnt_clear zeroes both counters on the next edge and wins over an increment in the same cycle.
- R9: Outside a frame, rx_valid bits and rx_eof have no effect. An rx_sof inside a frame restarts reception without an event.
- R10: After reset, frm_evt is low, frm_status is zero and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_accept_short | input | 1 | Pass up frames below the minimum length |
| cfg_min_len | input | LEN_W | Minimum frame length in whole octets |
| cnt_clear | input | 1 | Synchronous clear of both error counters |
| rx_valid | input | 1 | rx_bit carries a frame bit this cycle |
| rx_bit | input | 1 | Serial data bit |
| rx_sof | input | 1 | Marks the first bit of a frame (with rx_valid) |
| rx_eof | input | 1 | Frame end marker; carries no bit |
| frm_evt | output | 1 | One-cycle frame-completed strobe |
| frm_status | output | 4 | [0] CRC error, [1] alignment error, [2] short, [3] passed |
| frm_octets | output | LEN_W | Whole octets in the last frame, saturating |
| crc_err_count | output | CNT_W | Saturating CRC error count |
| align_err_count | output | CNT_W | Saturating alignment error count |

## Verification
A corrupted CRC register or octet snapshot shows up at the very next frame end, as a wrong bit 0 or bit 1 in frm_status and as the wrong counter moving in that same cycle. A bit counter that drifts shows up as the wrong class (alignment versus CRC) or as a wrong frm_octets value on the next frame. A stuck state machine shows up either as a missing frm_evt one cycle after rx_eof or as a spurious strobe for a stray end marker while hunting. The bench sweeps every dribble count from zero to seven against good and corrupted frames of several lengths. It uses a three-bit counter build so that saturation is reached within the sweep.

// File: rtl/ethrx_pkg.sv
package ethrx_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE   = 32'hC704DD7B;

    localparam int CNT_CRC   = 0;
    localparam int CNT_ALIGN = 1;
    localparam int NUM_CNT   = 2;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } rx_fsm_t;

    // packed MSB first: passed=[3] short=[2] align=[1] crc=[0]
    typedef struct packed {
        logic passed;
        logic short_frm;
        logic align_err;
        logic crc_err;
    } rx_status_t;

    function automatic logic [31:0] reflect32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/ethrx_crc_step.sv
module ethrx_crc_step #(
    parameter int          CRC_W = 32,
    parameter logic [31:0] POLY  = ethrx_pkg::CRC_POLY_REFL
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic feedback;

    always_comb begin
        feedback = crc_in[0] ^ bit_in;
        crc_out  = (crc_in >> 1) ^ (feedback ? POLY[CRC_W-1:0] : '0);
    end

endmodule

// File: rtl/ethrx_sat_counter.sv
module ethrx_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/eth_rx_frame_checker.sv
module eth_rx_frame_checker
    import ethrx_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_accept_short,
    input  logic [LEN_W-1:0] cfg_min_len,
    input  logic             cnt_clear,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             frm_evt,
    output logic [3:0]       frm_status,
    output logic [LEN_W-1:0] frm_octets,
    output logic [CNT_W-1:0] crc_err_count,
    output logic [CNT_W-1:0] align_err_count
);
    localparam logic [31:0]      GOOD_REG = reflect32(CRC_RESIDUE);
    localparam logic [LEN_W-1:0] OCT_MAX  = '1;

    typedef struct packed {
        rx_fsm_t          fsm;
        logic [31:0]      crc;
        logic [31:0]      crc_oct;
        logic [2:0]       bitcnt;
        logic [LEN_W-1:0] octets;
        logic             evt;
        rx_status_t       status;
        logic [LEN_W-1:0] len_out;
    } regs_t;

    regs_t r_d, r_q;

    logic             start;
    logic [31:0]      crc_base, crc_step;
    logic [2:0]       cnt_base;
    logic [LEN_W-1:0] oct_base;
    logic             octet_done;
    logic             dribble, crc_bad;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    ethrx_crc_step #(.CRC_W(32), .POLY(CRC_POLY_REFL)) u_crc (
        .crc_in  (crc_base),
        .bit_in  (rx_bit),
        .crc_out (crc_step)
    );

    always_comb begin
        start      = rx_valid && rx_sof && !rx_eof;
        crc_base   = start ? '1 : r_q.crc;
        cnt_base   = start ? 3'd0 : r_q.bitcnt;
        oct_base   = start ? '0 : r_q.octets;
        octet_done = (cnt_base == 3'd7);
        dribble    = (r_q.bitcnt != 3'd0);
        crc_bad    = (r_q.crc_oct != GOOD_REG);
        cnt_inc    = '0;

        r_d     = r_q;
        r_d.evt = 1'b0;

        if (r_q.fsm == ST_RECV && rx_eof) begin
            r_d.fsm              = ST_HUNT;
            r_d.evt              = 1'b1;
            r_d.len_out          = r_q.octets;
            r_d.status.align_err = dribble && crc_bad;
            r_d.status.crc_err   = !dribble && crc_bad;
            r_d.status.short_frm = (r_q.octets < cfg_min_len);
            r_d.status.passed    = (r_q.octets >= cfg_min_len) || cfg_accept_short;
            cnt_inc[CNT_CRC]     = !dribble && crc_bad;
            cnt_inc[CNT_ALIGN]   = dribble && crc_bad;
        end else if (start || (r_q.fsm == ST_RECV && rx_valid && !rx_eof)) begin
            r_d.fsm     = ST_RECV;
            r_d.crc     = crc_step;
            r_d.bitcnt  = cnt_base + 3'd1;
            r_d.octets  = oct_base;
            r_d.crc_oct = start ? '1 : r_q.crc_oct;
            if (octet_done) begin
                r_d.crc_oct = crc_step;
                r_d.octets  = (oct_base == OCT_MAX) ? oct_base : oct_base + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.fsm     <= ST_HUNT;
            r_q.crc     <= '1;
            r_q.crc_oct <= '1;
            r_q.bitcnt  <= '0;
            r_q.octets  <= '0;
            r_q.evt     <= 1'b0;
            r_q.status  <= '0;
            r_q.len_out <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        ethrx_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clear),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    assign frm_evt         = r_q.evt;
    assign frm_status      = r_q.status;
    assign frm_octets      = r_q.len_out;
    assign crc_err_count   = cnt_val[CNT_CRC];
    assign align_err_count = cnt_val[CNT_ALIGN];

    p_evt_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_evt |=> !frm_evt);

    p_one_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_evt |-> !(r_q.status.crc_err && r_q.status.align_err));

    p_align_dribble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_evt && r_q.status.align_err) |-> $past(r_q.bitcnt) != 3'd0);

    p_long_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_evt && !r_q.status.short_frm) |-> r_q.status.passed);

    p_hunt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == ST_HUNT) |=> !frm_evt);

    p_one_counter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_inc[CNT_CRC] && cnt_inc[CNT_ALIGN]));

endmodule

// File: tb/tb_eth_rx_frame_checker.sv
`timescale 1ns/1ps
module tb_eth_rx_frame_checker;
    localparam int LEN_W = 8;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int MINL  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_accept_short = 1'b0;
    logic [LEN_W-1:0] cfg_min_len = LEN_W'(MINL);
    logic cnt_clear = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic frm_evt;
    logic [3:0] frm_status;
    logic [LEN_W-1:0] frm_octets;
    logic [CNT_W-1:0] crc_err_count, align_err_count;

    int checks = 0, errors = 0;
    int exp_crc = 0, exp_align = 0;
    int cycles = 0;
    bit done = 0;
    logic [7:0] fb [0:15];

    always #2 clk = ~clk;

    eth_rx_frame_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_accept_short(cfg_accept_short),
        .cfg_min_len(cfg_min_len), .cnt_clear(cnt_clear),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .frm_evt(frm_evt), .frm_status(frm_status), .frm_octets(frm_octets),
        .crc_err_count(crc_err_count), .align_err_count(align_err_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] calc_fcs(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fbk = c[0] ^ fb[i][b];
                c = c >> 1;
                if (fbk) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic send_bit(input logic b, input logic s);
        @(negedge clk);
        rx_valid = 1'b1; rx_bit = b; rx_sof = s;
    endtask

    // n data octets + 4 FCS octets, d dribble bits, bad flips one FCS bit
    task automatic run_frame(input int n, input int d, input bit bad, input bit clr);
        logic [31:0] fcs;
        bit crc_e, al_e, sh;
        for (int i = 0; i < n; i++) fb[i] = 8'((n * 37 + i * 11 + 5) & 255);
        fcs = calc_fcs(n);
        for (int k = 0; k < 4; k++) fb[n+k] = fcs[8*k +: 8];
        if (bad) fb[n] = fb[n] ^ 8'h01;
        for (int i = 0; i < n + 4; i++)
            for (int b = 0; b < 8; b++)
                send_bit(fb[i][b], (i == 0 && b == 0));
        for (int k = 0; k < d; k++) send_bit(1'(k & 1), 1'b0);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1; cnt_clear = clr;
        @(negedge clk);
        rx_eof = 1'b0; cnt_clear = 1'b0;
        crc_e = bad && d == 0;
        al_e  = bad && d != 0;
        sh    = (n + 4) < MINL;
        if (clr) begin
            exp_crc = 0; exp_align = 0;
        end else begin
            if (crc_e && exp_crc < CMAX) exp_crc++;
            if (al_e && exp_align < CMAX) exp_align++;
        end
        check("R5 evt", int'(frm_evt), 1);
        check("R5 octets", int'(frm_octets), n + 4);
        check(d == 0 ? "R4 crc bit" : "R2 crc bit", int'(frm_status[0]), int'(crc_e));
        check(d == 0 ? "R1 align bit" : "R3 align bit", int'(frm_status[1]), int'(al_e));
        check("R6 short", int'(frm_status[2]), int'(sh));
        check("R6 passed", int'(frm_status[3]), int'(!sh || cfg_accept_short));
        check(clr ? "R8 crc count" : "R7 crc count", int'(crc_err_count), exp_crc);
        check(clr ? "R8 align count" : "R3 align count", int'(align_err_count), exp_align);
        @(negedge clk);
        check("R5 single pulse", int'(frm_evt), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 evt", int'(frm_evt), 0);
        check("R10 status", int'(frm_status), 0);
        check("R10 crc count", int'(crc_err_count), 0);
        check("R10 align count", int'(align_err_count), 0);

        // R1 R2 R3 R4 R6: sweep of lengths, dribble counts and corruption
        for (int n = 0; n < 6; n++)
            for (int d = 0; d < 8; d++)
                for (int bad = 0; bad < 2; bad++) begin
                    cfg_accept_short = 1'((n + d) & 1);
                    run_frame(n, d, bit'(bad), 1'b0);
                end

        // R7: drive the CRC counter into saturation
        for (int k = 0; k < 3; k++) run_frame(4, 0, 1'b1, 1'b0);

        // R8: clear in the same cycle as an increment
        run_frame(3, 0, 1'b1, 1'b1);
        run_frame(3, 5, 1'b1, 1'b0);

        // R9: stray bits and end marker while hunting
        for (int k = 0; k < 20; k++) begin
            send_bit(1'(k & 1), 1'b0);
            check("R9 no evt in hunt", int'(frm_evt), 0);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0;
        check("R9 stray eof", int'(frm_evt), 0);
        @(negedge clk);
        check("R9 stray eof late", int'(frm_evt), 0);
        check("R9 counters kept", int'(align_err_count), exp_align);
        run_frame(2, 0, 1'b0, 1'b0);

        // R9: restart in mid frame
        send_bit(1'b1, 1'b1);
        for (int k = 0; k < 12; k++) begin
            send_bit(1'(k % 3 == 0), 1'b0);
            check("R9 no evt mid frame", int'(frm_evt), 0);
        end
        run_frame(5, 3, 1'b0, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule